// File: doc/BRIEF.md
# Accelerator Host-Bus Write Poster

This block sits between a fast accelerator CPU and a slow host system bus and sends every committing CPU access to the right place. RAM reads come from fast local memory in the same cycle and never reach the host. RAM writes always go to local memory. A RAM write is also sent to the host when its page lies inside a programmable mirror window. Writes to the peripheral I/O region and to the attribute-RAM region always go to the host.

Every host write passes through a posted buffer that holds one byte and its address. The CPU keeps running while that buffer drains at the slow-bus rate. The CPU stalls only when it issues a new host-bound write while the buffer is still occupied. Host reads block the CPU until a real slow-bus read has finished. Such a read also waits for any posted write to finish first, so read-after-write order holds on the host bus. Non-committing (dummy) CPU cycles complete at once and touch nothing.

The slow bus is paced by a one-cycle tick input. One slow cycle is the span from one tick to the next. A small register port sets the inclusive first and last page of the mirror window.

Top module: `hb_write_poster`

## Requirements
- R1: A committing read of a RAM address is answered in the same cycle. `cpu_ready` is 1, `lm_en` is 1, `lm_we` is 0 and `cpu_rdata` equals `lm_rdata`. No host transaction follows. RAM is every page outside 0xD0..0xDF, where the page is address bits [15:8].
- R2: A committing RAM write always drives `lm_en` and `lm_we` with the CPU address and data. When its page is outside the mirror window, no host transaction follows.
- R3: A committing RAM write whose page p satisfies start <= p <= end is also sent to the host as one write with the same address and data. After reset, start is 0x00 and end is 0xFF.
- R4: A write to the attribute region (pages 0xD8..0xDB) or to the I/O region (pages 0xD0..0xDF apart from the attribute pages) produces exactly one host write with its address and data. It never drives `lm_en`.
- R5: The posted buffer holds one entry. A host-bound write is accepted in the cycle it is presented if the buffer is empty. Otherwise `cpu_ready` stays 0 until the pending entry has drained.
- R6: A host transaction starts only at a `bus_tick` and keeps `hb_valid`, `hb_we`, `hb_addr` and `hb_wdata` steady until it ends at a later tick. A write lasts one slow cycle. A write to a slow port address, (addr & 0xFEFE) == 0xDC00, lasts two slow cycles.
- R7: Host-bound writes spaced far enough apart for the previous entry to drain are accepted with no stall. That is 4 slow cycles after a normal write and 6 after a slow-port write.
- R8: A committing read of the I/O or attribute region holds `cpu_ready` at 0 until a one-slow-cycle host read has ended. `hb_rdata` is captured at that ending tick and returned on `cpu_rdata`.
- R9: A host read issued while a posted write is pending starts only after that write has ended, so the host sees the write first.
- R10: A CPU cycle with `cpu_last` = 0 completes at once with `cpu_ready` = 1. It drives no local access and no host transaction.
- R11: `cfg_we` with `cfg_sel` = 0 loads the window start page from `cfg_wdata`, and `cfg_sel` = 1 loads the end page. The new window governs later RAM writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_last | input | 1 | 1 = committing cycle of the access |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid with ready |
| cpu_ready | output | 1 | Access completes this cycle |
| lm_en | output | 1 | Local memory access strobe |
| lm_we | output | 1 | Local memory write enable |
| lm_addr | output | 16 | Local memory address |
| lm_wdata | output | 8 | Local memory write data |
| lm_rdata | input | 8 | Local memory read data, same cycle |
| bus_tick | input | 1 | One-cycle strobe marking each slow-bus cycle boundary |
| hb_valid | output | 1 | Host transaction in progress |
| hb_we | output | 1 | Host transaction is a write |
| hb_addr | output | 16 | Host address |
| hb_wdata | output | 8 | Host write data |
| hb_rdata | input | 8 | Host read data, sampled at the ending tick |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 1 | 0 = window start page, 1 = window end page |
| cfg_wdata | input | 8 | Page value to load |

## Verification
The assertions assume that the CPU holds its request and its address steady while `cpu_ready` is 0. They also assume that the CPU never presents a new write while it is itself blocked on a host read. The bench keeps to both rules, because every access runs through one task. That task holds the request until ready and then drops it for a cycle before the next access. The tick is a regular strobe every fourth clock, so both the start-on-tick property and the two-slow-cycle port drain are exercised at a fixed and known phase.

// File: rtl/hb_pkg.sv
// Shared types for the host-bus write poster.
package hb_pkg;
    // Address class of a CPU access.
    typedef enum logic [1:0] {
        RG_RAM  = 2'd0,
        RG_IO   = 2'd1,
        RG_ATTR = 2'd2
    } region_e;

    // State of the single host-bus transaction engine.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;
endpackage

// File: rtl/hb_decode.sv
// Address classifier.
// What: splits an address into RAM, I/O or attribute region, flags the
// slow port addresses and tests the page against the mirror window.
// Assumes: the attribute pages lie inside or beside the I/O pages and win
// over them; the window bounds are inclusive.
module hb_decode
    import hb_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8,
    parameter logic [PW-1:0] IO_LO_PG   = 'hD0,
    parameter logic [PW-1:0] IO_HI_PG   = 'hDF,
    parameter logic [PW-1:0] ATTR_LO_PG = 'hD8,
    parameter logic [PW-1:0] ATTR_HI_PG = 'hDB,
    parameter logic [AW-1:0] PORT_MASK  = 'hFEFE,
    parameter logic [AW-1:0] PORT_MATCH = 'hDC00
) (
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] win_lo,
    input  logic [PW-1:0] win_hi,
    output region_e       region,
    output logic          in_window,
    output logic          slow_port
);
    logic [PW-1:0] page;
    assign page = addr[AW-1 -: PW];

    // Region select, attribute pages taking priority over I/O pages.
    always_comb begin
        region = RG_RAM;
        if (page >= ATTR_LO_PG && page <= ATTR_HI_PG)
            region = RG_ATTR;
        else if (page >= IO_LO_PG && page <= IO_HI_PG)
            region = RG_IO;
    end

    // Mirror window and slow port tests.
    always_comb begin
        in_window = (page >= win_lo) && (page <= win_hi);
        slow_port = (region == RG_IO) && ((addr & PORT_MASK) == PORT_MATCH);
    end
endmodule

// File: rtl/hb_window_regs.sv
// Mirror window registers.
// What: holds the inclusive first and last mirrored page.
// Assumes: software keeps start <= end when it wants a non-empty window.
module hb_window_regs #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [PW-1:0] cfg_wdata,
    output logic [PW-1:0] win_lo,
    output logic [PW-1:0] win_hi
);
    // Load one bound per write; reset opens the window over all pages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_lo <= '0;
            win_hi <= '1;
        end else if (cfg_we) begin
            if (cfg_sel) win_hi <= cfg_wdata;
            else         win_lo <= cfg_wdata;
        end
    end
endmodule

// File: rtl/hb_post_buf.sv
// Single-entry posted write buffer and host-bus transaction engine.
// What: keeps one byte and its address until its host write has ended,
// runs blocking reads, and starts and ends every transaction on a tick.
// Assumes: push only arrives while the buffer is empty; rd_req and rd_addr
// stay steady until rd_valid is acknowledged; no push during a read.
module hb_post_buf
    import hb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SLOW_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          push_slow,
    output logic          buf_full,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          hb_valid,
    output logic          hb_we,
    output logic [AW-1:0] hb_addr,
    output logic [DW-1:0] hb_wdata,
    input  logic [DW-1:0] hb_rdata
);
    localparam int CW = $clog2(SLOW_TICKS + 1);

    phase_e        phase;
    logic [CW-1:0] left;
    logic          buf_slow;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_data;
    logic [AW-1:0] rd_addr_q;

    // Buffer fill, transaction start and end, read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            left      <= '0;
            buf_full  <= 1'b0;
            buf_slow  <= 1'b0;
            buf_addr  <= '0;
            buf_data  <= '0;
            rd_addr_q <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (push) begin
                buf_full <= 1'b1;
                buf_slow <= push_slow;
                buf_addr <= push_addr;
                buf_data <= push_data;
            end
            if (rd_ack)
                rd_valid <= 1'b0;
            if (tick) begin
                case (phase)
                    PH_IDLE: begin
                        if (buf_full) begin
                            phase <= PH_WRITE;
                            left  <= buf_slow ? CW'(SLOW_TICKS) : CW'(1);
                        end else if (rd_req && !rd_valid) begin
                            phase     <= PH_READ;
                            rd_addr_q <= rd_addr;
                            left      <= CW'(1);
                        end
                    end
                    PH_WRITE: begin
                        if (left == CW'(1)) begin
                            phase    <= PH_IDLE;
                            buf_full <= 1'b0;
                        end
                        left <= left - CW'(1);
                    end
                    PH_READ: begin
                        phase    <= PH_IDLE;
                        rd_data  <= hb_rdata;
                        rd_valid <= 1'b1;
                        left     <= '0;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // Host bus outputs straight from the engine registers.
    always_comb begin
        hb_valid = (phase != PH_IDLE);
        hb_we    = (phase == PH_WRITE);
        hb_addr  = (phase == PH_WRITE) ? buf_addr : rd_addr_q;
        hb_wdata = buf_data;
    end

    // R5: the single entry is never overwritten while occupied.
    a_r5_push_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !buf_full);

    // R6: a transaction only begins right after a tick.
    a_r6_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_valid) |-> $past(tick));

    // R6: the bus is held steady between ticks.
    a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && !tick) |=> (hb_valid && $stable(hb_we) && $stable(hb_addr)
                                 && $stable(hb_wdata)));

    // R9: a host read never runs while a posted write is pending.
    a_r9_read_behind_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && !hb_we) |-> !buf_full);
endmodule

// File: rtl/hb_write_poster.sv
// Top of the host-bus write poster.
// What: routes each committing CPU access to local memory, to the posted
// buffer or to a blocking host read, and generates ready.
// Assumes: the CPU holds request, address and data while ready is low and
// local memory answers reads in the same cycle.
module hb_write_poster
    import hb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PW = 8,
    parameter int SLOW_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_last,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    output logic          lm_en,
    output logic          lm_we,
    output logic [AW-1:0] lm_addr,
    output logic [DW-1:0] lm_wdata,
    input  logic [DW-1:0] lm_rdata,
    input  logic          bus_tick,
    output logic          hb_valid,
    output logic          hb_we,
    output logic [AW-1:0] hb_addr,
    output logic [DW-1:0] hb_wdata,
    input  logic [DW-1:0] hb_rdata,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [PW-1:0] cfg_wdata
);
    logic [PW-1:0] win_lo, win_hi;
    region_e       region;
    logic          in_win, slow_port;
    logic          commit, host_rgn, wr_host, rd_host, push;
    logic          buf_full, rd_valid;
    logic [DW-1:0] rd_data;

    hb_window_regs #(.PW(PW)) u_win (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .win_lo(win_lo), .win_hi(win_hi)
    );

    hb_decode #(.AW(AW), .PW(PW)) u_dec (
        .addr(cpu_addr), .win_lo(win_lo), .win_hi(win_hi),
        .region(region), .in_window(in_win), .slow_port(slow_port)
    );

    // Classify the present access.
    always_comb begin
        commit   = cpu_req && cpu_last;
        host_rgn = (region != RG_RAM);
        wr_host  = commit && cpu_we && (host_rgn || in_win);
        rd_host  = commit && !cpu_we && host_rgn;
        push     = wr_host && !buf_full;
    end

    hb_post_buf #(.AW(AW), .DW(DW), .SLOW_TICKS(SLOW_TICKS)) u_buf (
        .clk(clk), .rst_n(rst_n), .tick(bus_tick),
        .push(push), .push_addr(cpu_addr), .push_data(cpu_wdata),
        .push_slow(slow_port), .buf_full(buf_full),
        .rd_req(rd_host), .rd_addr(cpu_addr), .rd_ack(rd_host && rd_valid),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .hb_valid(hb_valid), .hb_we(hb_we), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata)
    );

    // Ready: dummy cycles and local accesses at once, host accesses on room or data.
    always_comb begin
        if (!cpu_req)       cpu_ready = 1'b0;
        else if (!cpu_last) cpu_ready = 1'b1;
        else if (cpu_we)    cpu_ready = wr_host ? !buf_full : 1'b1;
        else                cpu_ready = host_rgn ? rd_valid : 1'b1;
    end

    // Local memory port; a mirrored write touches it only when accepted.
    always_comb begin
        lm_en     = commit && !host_rgn && (!cpu_we || !wr_host || !buf_full);
        lm_we     = cpu_we;
        lm_addr   = cpu_addr;
        lm_wdata  = cpu_wdata;
        cpu_rdata = host_rgn ? rd_data : lm_rdata;
    end

    // R1: a committing RAM read is served locally in the same cycle.
    a_r1_ram_read_local: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !cpu_we && region == RG_RAM) |-> (cpu_ready && lm_en && !lm_we));

    // R10: dummy cycles complete at once and reach neither memory nor buffer.
    a_r10_dummy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_last) |-> (cpu_ready && !lm_en && !push));
endmodule

// File: tb/tb_hb_write_poster.sv
module tb_hb_write_poster;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int LOGN       = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_last = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        lm_en, lm_we;
    logic [15:0] lm_addr;
    logic [7:0]  lm_wdata, lm_rdata;
    logic        bus_tick = 1'b0;
    logic        hb_valid, hb_we;
    logic [15:0] hb_addr;
    logic [7:0]  hb_wdata, hb_rdata;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;

    hb_write_poster dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_last(cpu_last), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .lm_en(lm_en),
        .lm_we(lm_we), .lm_addr(lm_addr), .lm_wdata(lm_wdata),
        .lm_rdata(lm_rdata), .bus_tick(bus_tick), .hb_valid(hb_valid),
        .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
        .hb_rdata(hb_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory and host models computed from the address.
    assign lm_rdata = lm_addr[7:0] + lm_addr[15:8];
    assign hb_rdata = hb_addr[7:0] ^ hb_addr[15:8] ^ 8'h3C;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0;
    int tdiv = 0;

    // Regular slow-bus tick, changed away from the active edge.
    always @(negedge clk) begin
        tdiv = (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        bus_tick = (tdiv == TICK_DIV-1);
    end
    always @(posedge clk) cyc++;

    // Host log: one entry per slow cycle that a transaction occupies.
    logic        log_we   [LOGN];
    logic [15:0] log_addr [LOGN];
    logic [7:0]  log_data [LOGN];
    int log_n = 0;
    always @(negedge clk) begin
        #3;
        if (rst_n && bus_tick && hb_valid && log_n < LOGN) begin
            log_we[log_n]   = hb_we;
            log_addr[log_n] = hb_addr;
            log_data[log_n] = hb_wdata;
            log_n++;
        end
    end

    logic [7:0] win_lo_m = 8'h00, win_hi_m = 8'hFF;

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
    end

    // Last access results.
    int         a_waits;
    logic [7:0] a_rdata;
    logic       a_lm_en, a_lm_we;
    logic [15:0] a_lm_addr;
    logic [7:0]  a_lm_wdata;

    task automatic access(input bit we, input bit last, input logic [15:0] addr,
                          input logic [7:0] data);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_last = last;
        cpu_addr = addr; cpu_wdata = data;
        a_waits = 0;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            a_waits++;
        end
        a_rdata = cpu_rdata; a_lm_en = lm_en; a_lm_we = lm_we;
        a_lm_addr = lm_addr; a_lm_wdata = lm_wdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_last = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_win(input bit sel, input logic [7:0] pg);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = pg;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) win_hi_m = pg; else win_lo_m = pg;
    endtask

    function automatic int region_of(input logic [15:0] a);
        if (a[15:8] >= 8'hD8 && a[15:8] <= 8'hDB) return 2;
        if (a[15:8] >= 8'hD0 && a[15:8] <= 8'hDF) return 1;
        return 0;
    endfunction

    function automatic int host_entries(input logic [15:0] a);
        int r = region_of(a);
        if (r == 0) return (a[15:8] >= win_lo_m && a[15:8] <= win_hi_m) ? 1 : 0;
        if (r == 1 && ((a & 16'hFEFE) == 16'hDC00)) return 2;
        return 1;
    endfunction

    // Write, let it drain, compare local strobe and host log with the model.
    task automatic write_check(input logic [15:0] a, input logic [7:0] d, input string req);
        int n0 = log_n;
        int exp_n = host_entries(a);
        bit ram = (region_of(a) == 0);
        access(1'b1, 1'b1, a, d);
        idle(6 * TICK_DIV);
        check(log_n - n0 == exp_n, req, $sformatf("host entries for %h", a), log_n - n0, exp_n);
        for (int i = n0; i < log_n; i++)
            check(log_we[i] && log_addr[i] == a && log_data[i] == d, req,
                  $sformatf("host write content for %h", a), {log_addr[i], log_data[i]}, {a, d});
        if (ram)
            check(a_lm_en && a_lm_we && a_lm_addr == a && a_lm_wdata == d, "R2",
                  $sformatf("local write for %h", a), {a_lm_en, a_lm_we, a_lm_addr}, {2'b11, a});
        else
            check(!a_lm_en, "R4", $sformatf("no local access for %h", a), a_lm_en, 0);
    endtask

    task automatic read_check(input logic [15:0] a);
        int n0 = log_n;
        bit ram = (region_of(a) == 0);
        logic [7:0] exp_d;
        access(1'b0, 1'b1, a, 8'h00);
        idle(2);
        if (ram) begin
            exp_d = a[7:0] + a[15:8];
            check(a_rdata == exp_d && a_waits == 0 && a_lm_en && !a_lm_we, "R1",
                  $sformatf("local read %h", a), {a_waits[7:0], a_rdata}, {8'd0, exp_d});
            check(log_n == n0, "R1", "no host access on RAM read", log_n - n0, 0);
        end else begin
            exp_d = a[7:0] ^ a[15:8] ^ 8'h3C;
            check(a_rdata == exp_d && a_waits > 0, "R8",
                  $sformatf("host read %h", a), a_rdata, exp_d);
            check(log_n == n0 + 1 && !log_we[n0] && log_addr[n0] == a, "R8",
                  "one host read cycle", log_n - n0, 1);
        end
    endtask

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!cpu_ready && !hb_valid && !lm_en, "R5", "reset state idle",
              {cpu_ready, hb_valid, lm_en}, 0);

        // R3: reset window spans every page.
        write_check(16'h0012, 8'hA1, "R3");
        write_check(16'hFF34, 8'hB2, "R3");

        // R11: program a window and sweep every page for writes and reads.
        set_win(1'b0, 8'h20);
        set_win(1'b1, 8'h3F);
        for (int p = 0; p < 256; p++)
            write_check({p[7:0], 7'b0, p[1]}, p[7:0] ^ 8'h96,
                        (p >= 8'hD0 && p <= 8'hDF) ? "R4" : "R3");
        for (int p = 0; p < 256; p++)
            read_check({p[7:0], p[7:0] ^ 8'hA5});

        // R11: single-page window.
        set_win(1'b0, 8'h80);
        set_win(1'b1, 8'h80);
        write_check(16'h7F01, 8'h11, "R11");
        write_check(16'h8002, 8'h22, "R11");
        write_check(16'h8103, 8'h33, "R11");

        // R6: slow port drains over two slow cycles, others over one.
        write_check(16'hDC01, 8'h5A, "R6");
        write_check(16'hDD00, 8'h6B, "R6");
        write_check(16'hDE00, 8'h7C, "R6");

        // R5: back-to-back host writes stall and both reach the host in order.
        n0 = log_n;
        access(1'b1, 1'b1, 16'hD020, 8'h01);
        check(a_waits == 0, "R5", "first write accepted at once", a_waits, 0);
        access(1'b1, 1'b1, 16'hD021, 8'h02);
        check(a_waits > 0, "R5", "second write stalls", a_waits, 1);
        idle(6 * TICK_DIV);
        check(log_n == n0 + 2 && log_addr[n0] == 16'hD020 && log_addr[n0+1] == 16'hD021,
              "R5", "order of stalled writes", log_n - n0, 2);

        // R7: spaced writes never stall.
        for (int k = 0; k < 4; k++) begin
            access(1'b1, 1'b1, 16'hD400 + 16'(k), 8'(k));
            check(a_waits == 0, "R7", "spaced write no stall", a_waits, 0);
            idle(4 * TICK_DIV);
        end
        access(1'b1, 1'b1, 16'hDC00, 8'h44);
        idle(6 * TICK_DIV);
        access(1'b1, 1'b1, 16'hD800, 8'h45);
        check(a_waits == 0, "R7", "write after drained port write", a_waits, 0);
        idle(6 * TICK_DIV);

        // R9: read right behind a posted write sees the write first.
        n0 = log_n;
        access(1'b1, 1'b1, 16'hD100, 8'h9E);
        access(1'b0, 1'b1, 16'hD101, 8'h00);
        check(a_rdata == (8'h01 ^ 8'hD1 ^ 8'h3C), "R9", "read data after write",
              a_rdata, 8'h01 ^ 8'hD1 ^ 8'h3C);
        check(log_n == n0 + 2 && log_we[n0] && !log_we[n0+1], "R9",
              "write precedes read on host", log_n - n0, 2);

        // R10: dummy cycles are silent.
        idle(6 * TICK_DIV);
        n0 = log_n;
        access(1'b1, 1'b0, 16'hD200, 8'h77);
        check(a_waits == 0 && !a_lm_en, "R10", "dummy write", {a_waits[7:0], a_lm_en}, 0);
        access(1'b0, 1'b0, 16'hD300, 8'h00);
        check(a_waits == 0 && !a_lm_en, "R10", "dummy io read", {a_waits[7:0], a_lm_en}, 0);
        access(1'b1, 1'b0, 16'h8000, 8'h78);
        check(!a_lm_en, "R10", "dummy ram write", a_lm_en, 0);
        idle(6 * TICK_DIV);
        check(log_n == n0, "R10", "no host traffic from dummies", log_n - n0, 0);

        summary();
    end
endmodule